// File: doc/BRIEF.md
# SPI Bulk Data Phase Framer

This block runs the data phase that follows a long block-transfer command on an SPI link. It sits between a byte-stream user interface and a byte-level shifter that moves one byte in each direction per handshake. A transfer starts with a single `start` pulse. That pulse carries a direction, a total byte count and a CRC-trailer enable. Command framing and the response echo belong to other logic.

**Write direction.** The framer cuts the payload into packets of at most `PKT_MAX` bytes. Before each packet it sends a start byte whose low bits say where the packet sits in the sequence. Payload bytes are taken from the source as the shifter accepts them. When CRC is enabled, two zero bytes close each packet. No reply is awaited, so the next packet starts at once.

**Read direction.** The framer transmits only zeros. Before each packet it hunts for a header byte whose upper nibble is all ones, giving up after a bounded number of misses. It then delivers the payload bytes to the sink. When CRC is enabled, it drops the two trailing bytes.

The states are:
- `S_IDLE`: waiting for a start pulse.
- `S_WSTART`: sending the write start byte.
- `S_WDATA`: sending write payload.
- `S_WCRC`: sending the write trailer.
- `S_RHDR`: hunting for the read header.
- `S_RDATA`: capturing read payload.
- `S_RCRC`: dropping the read trailer.

The transitions are:
- `S_IDLE` goes to `S_WSTART` or `S_RHDR` on an accepted start.
- `S_WSTART` goes to `S_WDATA` once the start byte is sent.
- `S_WDATA` goes to `S_WCRC`, `S_WSTART` or `S_IDLE` after the last byte of a packet.
- `S_WCRC` goes to `S_WSTART` or `S_IDLE` after its second byte.
- `S_RHDR` goes to `S_RDATA` on a header hit, or to `S_IDLE` on timeout.
- `S_RDATA` goes to `S_RCRC`, `S_RHDR` or `S_IDLE` after the last byte of a packet.
- `S_RCRC` goes to `S_RHDR` or `S_IDLE` after its second byte.

Top module: `spi_bulk_framer`

## Requirements
- R1: A start with `total_len` below 5 is rejected. One cycle later `done` and `err` pulse high together, and no shifter byte is requested.
- R2: Every write packet opens with the byte `8'hF0 | order`. `order` is 3 when the remaining length is at most `PKT_MAX`, 1 for the first of several packets, and 2 for any later packet that is not the last.
- R3: Write payload bytes follow the start byte in source order. A source byte is consumed (`src_ready` high) only in a cycle where the shifter accepts it.
- R4: With `crc_en` set at start, each packet (write or read) carries two trailer bytes after its payload. On write the trailer bytes are zero. With `crc_en` clear, there is no trailer.
- R5: On write, the next packet's start byte follows the previous packet immediately. After the last packet, `done` pulses with `err` low.
- R6: During a read transfer, every byte offered to the shifter is zero.
- R7: On read, a received byte with upper nibble 4'hF is a packet header. Up to 10 received bytes that are not headers are discarded before it without error.
- R8: If an 11th consecutive non-header byte arrives while hunting for a header, the transfer ends with `done` and `err` high.
- R9: Read payload bytes appear on `snk_data` with a one-cycle `snk_valid` pulse, in received order. Header and trailer bytes never reach the sink.
- R10: `busy` is high from an accepted start until the `done` pulse. A start pulse while busy has no effect.
- R11: After reset the block is idle: `busy`, `sh_valid`, `src_ready`, `snk_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| dir_rd | input | 1 | 1 = read, 0 = write |
| total_len | input | LEN_W | Total payload byte count |
| crc_en | input | 1 | Add or consume two trailer bytes per packet |
| src_data | input | 8 | Write payload byte from user |
| src_valid | input | 1 | Write payload byte available |
| src_ready | output | 1 | Write payload byte consumed this cycle |
| snk_data | output | 8 | Read payload byte to user |
| snk_valid | output | 1 | Read payload byte valid (one-cycle pulse) |
| sh_valid | output | 1 | Byte offered to the shifter |
| sh_tx | output | 8 | Byte to transmit |
| sh_ack | input | 1 | Shifter completes the byte exchange this cycle |
| sh_rx | input | 8 | Byte received in the exchange |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| err | output | 1 | With done: rejected length or header timeout |

## Verification
The checker covers, on every cycle, the properties that hold cycle by cycle:
- short-length rejection one cycle after start
- source consumption only on an accepted shifter exchange
- zero transmit data in read mode
- sink output only in read mode
- a quiet interface while idle

Other behaviour can only be shown by the bench's scenarios, which a reference model computes byte by byte:
- the order-code sequence across single-packet, two-packet and three-packet writes
- trailer insertion and removal
- header hunting with ten misses, which succeeds, against eleven misses, which times out
- a start pulse ignored mid-transfer

// File: rtl/spi_bulk_pkg.sv
package spi_bulk_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WSTART,
        S_WDATA,
        S_WCRC,
        S_RHDR,
        S_RDATA,
        S_RCRC
    } bulk_state_t;

    localparam logic [1:0] ORD_FIRST = 2'd1;
    localparam logic [1:0] ORD_MID   = 2'd2;
    localparam logic [1:0] ORD_LAST  = 2'd3;
    localparam logic [3:0] MARK_NIB  = 4'hF;
endpackage

// File: rtl/bulk_pkt_sizer.sv
module bulk_pkt_sizer #(
    parameter int LEN_W   = 24,
    parameter int PKT_MAX = 8192,
    localparam int PKT_W  = $clog2(PKT_MAX + 1)
) (
    input  logic [LEN_W-1:0] remain,
    input  logic             first,
    output logic [PKT_W-1:0] pkt_len,
    output logic [1:0]       order,
    output logic             fits
);
    import spi_bulk_pkg::*;

    always_comb begin
        fits    = (remain <= LEN_W'(PKT_MAX));
        pkt_len = fits ? remain[PKT_W-1:0] : PKT_W'(PKT_MAX);
        order   = fits ? ORD_LAST : (first ? ORD_FIRST : ORD_MID);
    end
endmodule

// File: rtl/bulk_hdr_detect.sv
module bulk_hdr_detect (
    input  logic [7:0] rx_byte,
    output logic       hit
);
    import spi_bulk_pkg::*;

    assign hit = (rx_byte[7:4] == MARK_NIB);
endmodule

// File: rtl/spi_bulk_framer.sv
module spi_bulk_framer #(
    parameter int LEN_W     = 24,
    parameter int PKT_MAX   = 8192,
    parameter int RETRY_MAX = 10,
    parameter int MIN_LEN   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_rd,
    input  logic [LEN_W-1:0] total_len,
    input  logic             crc_en,
    input  logic [7:0]       src_data,
    input  logic             src_valid,
    output logic             src_ready,
    output logic [7:0]       snk_data,
    output logic             snk_valid,
    output logic             sh_valid,
    output logic [7:0]       sh_tx,
    input  logic             sh_ack,
    input  logic [7:0]       sh_rx,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import spi_bulk_pkg::*;

    localparam int PKT_W = $clog2(PKT_MAX + 1);
    localparam int TRY_W = $clog2(RETRY_MAX + 1);

    bulk_state_t      st, nxt;
    logic [LEN_W-1:0] rem_q;
    logic [PKT_W-1:0] cnt_q;
    logic [TRY_W-1:0] tries_q;
    logic             first_q, fin_q, crc_q, crc_idx_q;

    logic [PKT_W-1:0] pkt_len;
    logic [1:0]       order;
    logic             fits, hdr_hit, xfer, accept, reject, timeout;
    logic             last_byte;

    bulk_pkt_sizer #(.LEN_W(LEN_W), .PKT_MAX(PKT_MAX)) u_sizer (
        .remain (rem_q),
        .first  (first_q),
        .pkt_len(pkt_len),
        .order  (order),
        .fits   (fits)
    );

    bulk_hdr_detect u_hdr (
        .rx_byte(sh_rx),
        .hit    (hdr_hit)
    );

    assign xfer      = sh_valid && sh_ack;
    assign accept    = (st == S_IDLE) && start;
    assign reject    = accept && (total_len < LEN_W'(MIN_LEN));
    assign timeout   = (st == S_RHDR) && xfer && !hdr_hit && (tries_q == TRY_W'(RETRY_MAX));
    assign last_byte = (cnt_q == PKT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (accept && !reject) nxt = dir_rd ? S_RHDR : S_WSTART;
            S_WSTART: if (xfer) nxt = S_WDATA;
            S_WDATA:  if (xfer && last_byte)
                          nxt = crc_q ? S_WCRC : (fin_q ? S_IDLE : S_WSTART);
            S_WCRC:   if (xfer && crc_idx_q) nxt = fin_q ? S_IDLE : S_WSTART;
            S_RHDR:   if (xfer) begin
                          if (hdr_hit)      nxt = S_RDATA;
                          else if (timeout) nxt = S_IDLE;
                      end
            S_RDATA:  if (xfer && last_byte)
                          nxt = crc_q ? S_RCRC : (fin_q ? S_IDLE : S_RHDR);
            S_RCRC:   if (xfer && crc_idx_q) nxt = fin_q ? S_IDLE : S_RHDR;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            cnt_q     <= '0;
            tries_q   <= '0;
            first_q   <= 1'b0;
            fin_q     <= 1'b0;
            crc_q     <= 1'b0;
            crc_idx_q <= 1'b0;
        end else if (accept) begin
            rem_q     <= total_len;
            first_q   <= 1'b1;
            tries_q   <= '0;
            crc_q     <= crc_en;
            crc_idx_q <= 1'b0;
        end else if (xfer) begin
            unique case (st)
                S_WSTART: begin
                    cnt_q   <= pkt_len;
                    fin_q   <= fits;
                    first_q <= 1'b0;
                end
                S_RHDR: begin
                    if (hdr_hit) begin
                        cnt_q   <= pkt_len;
                        fin_q   <= fits;
                        tries_q <= '0;
                    end else begin
                        tries_q <= tries_q + TRY_W'(1);
                    end
                end
                S_WDATA, S_RDATA: begin
                    cnt_q     <= cnt_q - PKT_W'(1);
                    rem_q     <= rem_q - LEN_W'(1);
                    crc_idx_q <= 1'b0;
                end
                S_WCRC, S_RCRC: crc_idx_q <= ~crc_idx_q;
                default: ;
            endcase
        end
    end

    // outputs: shifter and source handshake
    always_comb begin
        sh_valid  = 1'b0;
        sh_tx     = 8'h00;
        src_ready = 1'b0;
        unique case (st)
            S_WSTART: begin
                sh_valid = 1'b1;
                sh_tx    = {MARK_NIB, 2'b00, order};
            end
            S_WDATA: begin
                sh_valid  = src_valid;
                sh_tx     = src_data;
                src_ready = src_valid && sh_ack;
            end
            S_WCRC, S_RHDR, S_RDATA, S_RCRC: sh_valid = 1'b1;
            default: ;
        endcase
    end

    assign busy = (st != S_IDLE);

    // outputs: registered pulses and sink
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            snk_valid <= 1'b0;
            snk_data  <= 8'h00;
        end else begin
            done      <= reject || ((st != S_IDLE) && (nxt == S_IDLE));
            err       <= reject || timeout;
            snk_valid <= (st == S_RDATA) && xfer;
            if ((st == S_RDATA) && xfer) snk_data <= sh_rx;
        end
    end
endmodule

// File: rtl/spi_bulk_framer_chk.sv
module spi_bulk_framer_chk #(
    parameter int LEN_W   = 24,
    parameter int MIN_LEN = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             dir_rd,
    input logic [LEN_W-1:0] total_len,
    input logic             src_ready,
    input logic             snk_valid,
    input logic             sh_valid,
    input logic [7:0]       sh_tx,
    input logic             sh_ack,
    input logic             busy,
    input logic             done,
    input logic             err
);
    logic rd_mode;

    always_ff @(posedge clk) begin
        if (!rst_n)              rd_mode <= 1'b0;
        else if (start && !busy) rd_mode <= dir_rd;
    end

    AST_REJECT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && total_len < LEN_W'(MIN_LEN)) |=> (done && err)); // R1

    AST_SRC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (sh_valid && sh_ack && !rd_mode)); // R3

    AST_RD_TX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_mode && sh_valid) |-> (sh_tx == 8'h00)); // R6

    AST_SNK_RD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> rd_mode); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sh_valid && !src_ready)); // R11
endmodule

bind spi_bulk_framer spi_bulk_framer_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dir_rd   (dir_rd),
    .total_len(total_len),
    .src_ready(src_ready),
    .snk_valid(snk_valid),
    .sh_valid (sh_valid),
    .sh_tx    (sh_tx),
    .sh_ack   (sh_ack),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/spi_bulk_framer_bench.sv
`timescale 1ns/100ps
module spi_bulk_framer_bench;
    localparam int LEN_W = 16;
    localparam int PKT   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0, dir_rd = 1'b0, crc_en = 1'b0;
    logic [LEN_W-1:0] total_len = '0;
    logic [7:0]       src_data = 8'h00;
    logic             src_valid = 1'b0;
    logic             src_ready;
    logic [7:0]       snk_data;
    logic             snk_valid;
    logic             sh_valid;
    logic [7:0]       sh_tx;
    logic             sh_ack = 1'b0;
    logic [7:0]       sh_rx = 8'h00;
    logic             busy, done, err;

    spi_bulk_framer #(.LEN_W(LEN_W), .PKT_MAX(PKT), .RETRY_MAX(10), .MIN_LEN(5)) u_spi_bulk_framer (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd),
        .total_len(total_len), .crc_en(crc_en),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .snk_data(snk_data), .snk_valid(snk_valid),
        .sh_valid(sh_valid), .sh_tx(sh_tx), .sh_ack(sh_ack), .sh_rx(sh_rx),
        .busy(busy), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] src_q[$], exp_tx[$], rx_q[$], exp_rx[$];
    string      cur_req = "R2";
    logic       pop_src = 1'b0;

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk("watchdog", 1'b0, cyc, 0);
                finish_run();
            end
        end
    end

    // shifter and user-side model, compared every clock
    initial begin
        forever begin
            @(negedge clk);
            if (pop_src && src_q.size() > 0) void'(src_q.pop_front());
            pop_src   = 1'b0;
            src_valid = (src_q.size() > 0);
            src_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
            sh_ack    = 1'b0;
            #1;
            if (snk_valid) begin
                if (exp_rx.size() == 0) chk("R9", 1'b0, snk_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    chk("R9", snk_data == e, snk_data, e);
                end
            end
            if (sh_valid && (cyc % 3 != 1)) begin
                if (exp_tx.size() == 0) chk(cur_req, 1'b0, sh_tx, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    chk(cur_req, sh_tx == e, sh_tx, e);
                end
                sh_rx  = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
                sh_ack = 1'b1;
                #1;
                pop_src = src_ready;
            end
        end
    end

    // reference model for the write byte stream
    task automatic build_write(input int len, input logic crc, input int seed);
        int rem, first, n, b;
        rem = len; first = 1; b = 0;
        while (rem > 0) begin
            n = (rem <= PKT) ? rem : PKT;
            exp_tx.push_back(8'hF0 | ((rem <= PKT) ? 8'd3 : (first ? 8'd1 : 8'd2)));
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                d = 8'((seed + b * 7) & 8'hFF);
                exp_tx.push_back(d);
                src_q.push_back(d);
                b++;
            end
            if (crc) begin exp_tx.push_back(8'h00); exp_tx.push_back(8'h00); end
            rem -= n; first = 0;
        end
    endtask

    // reference model for one read packet: junk, header, data, trailer
    task automatic build_read_pkt(input int junk, input int n, input logic crc, input int seed);
        for (int j = 0; j < junk; j++) rx_q.push_back(8'h3C ^ 8'(j));
        rx_q.push_back(8'hF5);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((seed + i * 13) & 8'hFF);
            rx_q.push_back(d);
            exp_rx.push_back(d);
        end
        if (crc) begin rx_q.push_back(8'hAB); rx_q.push_back(8'hCD); end
    endtask

    task automatic read_zeros();
        for (int i = 0; i < rx_q.size(); i++) exp_tx.push_back(8'h00);
    endtask

    task automatic launch(input logic rd, input int len, input logic crc);
        @(negedge clk);
        dir_rd = rd; total_len = LEN_W'(len); crc_en = crc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req, input logic exp_err);
        int t;
        t = 0;
        while (!done && t < 2000) begin @(negedge clk); #0.5; t++; end
        chk(req, done == 1'b1, done, 1);
        chk(req, err == exp_err, err, exp_err);
        @(negedge clk);
        #1.5;
        chk(req, exp_tx.size() == 0 && exp_rx.size() == 0, exp_tx.size() + exp_rx.size(), 0);
        chk("R10", busy == 1'b0, busy, 0);
        rx_q.delete(); src_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        // R11 reset state
        chk("R11", {busy, sh_valid, src_ready, snk_valid, done, err} == 6'b0,
            {busy, sh_valid, src_ready, snk_valid, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #0.5;
        chk("R11", {busy, sh_valid, done, err} == 4'b0, {busy, sh_valid, done, err}, 0);

        // R1 short length rejected, no bytes
        cur_req = "R1";
        @(negedge clk);
        dir_rd = 1'b0; total_len = LEN_W'(4); crc_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #0.5;
        chk("R1", done && err, {done, err}, 2'b11);
        @(negedge clk); #1.5;
        chk("R1", !busy && !sh_valid, busy, 0);

        // R2 R4 single packet write with trailer
        cur_req = "R2";
        build_write(5, 1'b1, 8'h10);
        launch(1'b0, 5, 1'b1);
        wait_done("R4", 1'b0);

        // R2 R3 R5 three packets no trailer; R10 start while busy is ignored
        cur_req = "R3";
        build_write(40, 1'b0, 8'h21);
        launch(1'b0, 40, 1'b0);
        repeat (6) @(negedge clk);
        dir_rd = 1'b1; total_len = LEN_W'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R5", 1'b0);

        // R4 R5 two packets with trailers
        cur_req = "R4";
        build_write(32, 1'b1, 8'h40);
        launch(1'b0, 32, 1'b1);
        wait_done("R5", 1'b0);

        // R6 R7 R9 R4 read two packets with trailer and header hunting
        cur_req = "R6";
        build_read_pkt(2, 16, 1'b1, 8'h55);
        build_read_pkt(0, 4, 1'b1, 8'h77);
        read_zeros();
        launch(1'b1, 20, 1'b1);
        wait_done("R9", 1'b0);

        // R7 ten misses then header succeeds
        cur_req = "R7";
        build_read_pkt(10, 6, 1'b0, 8'h91);
        read_zeros();
        launch(1'b1, 6, 1'b0);
        wait_done("R7", 1'b0);

        // R8 eleven misses time out
        cur_req = "R8";
        for (int j = 0; j < 11; j++) rx_q.push_back(8'h70);
        read_zeros();
        rx_q.push_back(8'hF5);
        launch(1'b1, 6, 1'b0);
        wait_done("R8", 1'b1);

        finish_run();
    end
endmodule